// File: doc/BRIEF.md
# Dual-Input Presettable Up/Down Counter

This block is a small binary counter that is steered by two separate count inputs rather than by one clock and a direction pin. A rising edge on the increment input adds one to the count. A rising edge on the decrement input subtracts one. The other input must be resting high for the edge to count. The block runs entirely on one fast system clock. It passes both count inputs through a short synchronizer and acts on the low-to-high transitions it sees there.

An asynchronous clear forces the count to zero at any moment. A sampled active-low load copies a data word into the count and overrides counting. Two active-low limit outputs each mirror the low phase of their own count input while the counter rests at its top value or at zero. When one stage's limit outputs are wired to the next stage's count inputs, the stages form a wider counter. An edge pattern that cannot be resolved leaves the count unchanged and raises a sticky fault flag.

Top module: `updn_dual_counter`

## Requirements
- R1: With the load inactive, a rising edge on `inc_in` while `dec_in` rests high adds one to `count_o`.
- R2: With the load inactive, a rising edge on `dec_in` while `inc_in` rests high subtracts one from `count_o`.
- R3: `clr` is active high and asynchronous. While it is high, `count_o` is 0 and `fault_o` is 0, regardless of every other input.
- R4: While `load_n` is low at a system clock edge, `count_o` takes `data_in` at that edge, and any count edge in that cycle is ignored.
- R5: `carry_n` is low only while `count_o` is the all-ones value and the synchronized `inc_in` is low. It returns high when `inc_in` rises.
- R6: `borrow_n` is low only while `count_o` is 0 and the synchronized `dec_in` is low.
- R7: Counting wraps around, from all-ones up to 0 and from 0 down to all-ones.
- R8: If both count inputs rise on the same sample, or if one rises while the other is low, the count holds and `fault_o` goes high. `fault_o` stays high until `clr`.
- R9: With 2 synchronizer stages, a count input that changes between clock edges moves `count_o` at the third rising clock edge after the change.
- R10: When two stages are chained, with `carry_n` driving the next stage's `inc_in` and `borrow_n` driving its `dec_in`, they count as one counter of twice the width in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| clr | input | 1 | Asynchronous clear, active high |
| load_n | input | 1 | Sampled parallel load, active low |
| data_in | input | CNT_W | Value copied in by the load |
| inc_in | input | 1 | Count-up input, acts on rising edge |
| dec_in | input | 1 | Count-down input, acts on rising edge |
| count_o | output | CNT_W | Current count |
| carry_n | output | 1 | Active-low top-limit output, follows `inc_in` low phase at all-ones |
| borrow_n | output | 1 | Active-low bottom-limit output, follows `dec_in` low phase at zero |
| fault_o | output | 1 | Sticky flag for unresolvable edge patterns |

## Verification
The bench drives full sweeps of increment pulses and of decrement pulses, past the wrap point in each direction. These show that direction comes from which input pulses, and that each limit output falls only in its own input's low phase at its own limit value. It loads every possible data value, holds the load through a count pulse, and raises the clear while the load is held, which separates load priority from clear priority. It also checks one edge timed to the exact clock cycle, illegal orderings of the two inputs (one rising while the other is low, and both rising together), and a two-stage chain counted up and down across the borrow from the upper stage.

// File: rtl/updn_pkg.sv
package updn_pkg;

    typedef enum logic [1:0] {
        STEP_NONE  = 2'd0,
        STEP_INC   = 2'd1,
        STEP_DEC   = 2'd2,
        STEP_FAULT = 2'd3
    } step_e;

endpackage

// File: rtl/updn_edge_sync.sv
module updn_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic clr,
    input  logic din,
    output logic level,
    output logic rise
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.chain[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            sync_d.chain[i] = sync_q.chain[i-1];
        end
        sync_d.prev = sync_q.chain[LAST];
    end

    // Idle level of a count input is high; resetting to ones avoids a
    // spurious rise right after clear.
    always_ff @(posedge clk or posedge clr) begin
        if (clr) sync_q <= '1;
        else     sync_q <= sync_d;
    end

    assign level = sync_q.chain[LAST];
    assign rise  = sync_q.chain[LAST] & ~sync_q.prev;

endmodule

// File: rtl/updn_step_decode.sv
module updn_step_decode
    import updn_pkg::*;
(
    input  logic  up_lvl,
    input  logic  up_rise,
    input  logic  dn_lvl,
    input  logic  dn_rise,
    output step_e step
);
    always_comb begin
        if (up_rise && dn_rise)  step = STEP_FAULT;
        else if (up_rise)        step = dn_lvl ? STEP_INC : STEP_FAULT;
        else if (dn_rise)        step = up_lvl ? STEP_DEC : STEP_FAULT;
        else                     step = STEP_NONE;
    end
endmodule

// File: rtl/updn_count_core.sv
module updn_count_core
    import updn_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         load_n,
    input  logic [W-1:0] data_in,
    input  step_e        step,
    output logic [W-1:0] count,
    output logic         fault
);
    typedef struct packed {
        logic [W-1:0] count;
        logic         fault;
    } core_t;

    core_t core_d, core_q;

    always_comb begin
        core_d = core_q;
        if (!load_n) begin
            core_d.count = data_in;
        end else begin
            case (step)
                STEP_INC: core_d.count = core_q.count + 1'b1;
                STEP_DEC: core_d.count = core_q.count - 1'b1;
                default:  core_d.count = core_q.count;
            endcase
        end
        if (step == STEP_FAULT) core_d.fault = 1'b1;
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr) core_q <= '0;
        else     core_q <= core_d;
    end

    assign count = core_q.count;
    assign fault = core_q.fault;

endmodule

// File: rtl/updn_limit_flag.sv
module updn_limit_flag #(
    parameter int W      = 4,
    parameter bit AT_TOP = 1'b1
) (
    input  logic [W-1:0] count,
    input  logic         lvl,
    output logic         flag_n
);
    localparam logic [W-1:0] LIMIT = AT_TOP ? {W{1'b1}} : {W{1'b0}};

    assign flag_n = ~((count == LIMIT) & ~lvl);
endmodule

// File: rtl/updn_dual_counter.sv
module updn_dual_counter
    import updn_pkg::*;
#(
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             load_n,
    input  logic [CNT_W-1:0] data_in,
    input  logic             inc_in,
    input  logic             dec_in,
    output logic [CNT_W-1:0] count_o,
    output logic             carry_n,
    output logic             borrow_n,
    output logic             fault_o
);
    logic  up_lvl, up_rise, dn_lvl, dn_rise;
    step_e step;

    updn_edge_sync #(.STAGES(SYNC_STAGES)) u_up_sync (
        .clk(clk), .clr(clr), .din(inc_in), .level(up_lvl), .rise(up_rise)
    );

    updn_edge_sync #(.STAGES(SYNC_STAGES)) u_dn_sync (
        .clk(clk), .clr(clr), .din(dec_in), .level(dn_lvl), .rise(dn_rise)
    );

    updn_step_decode u_decode (
        .up_lvl(up_lvl), .up_rise(up_rise),
        .dn_lvl(dn_lvl), .dn_rise(dn_rise),
        .step(step)
    );

    updn_count_core #(.W(CNT_W)) u_core (
        .clk(clk), .clr(clr), .load_n(load_n), .data_in(data_in),
        .step(step), .count(count_o), .fault(fault_o)
    );

    updn_limit_flag #(.W(CNT_W), .AT_TOP(1'b1)) u_carry (
        .count(count_o), .lvl(up_lvl), .flag_n(carry_n)
    );

    updn_limit_flag #(.W(CNT_W), .AT_TOP(1'b0)) u_borrow (
        .count(count_o), .lvl(dn_lvl), .flag_n(borrow_n)
    );

endmodule

// File: rtl/updn_dual_counter_chk.sv
module updn_dual_counter_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             clr,
    input logic             load_n,
    input logic [CNT_W-1:0] data_in,
    input logic             inc_in,
    input logic             dec_in,
    input logic [CNT_W-1:0] count_o,
    input logic             carry_n,
    input logic             borrow_n,
    input logic             fault_o,
    input logic             up_lvl,
    input logic             up_rise,
    input logic             dn_lvl,
    input logic             dn_rise
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    // R1, R7: legal up edge increments with wrap
    a_r1_increment: assert property (@(posedge clk) disable iff (clr)
        (load_n && up_rise && !dn_rise && dn_lvl) |=> count_o == $past(count_o) + 1'b1);

    // R2, R7: legal down edge decrements with wrap
    a_r2_decrement: assert property (@(posedge clk) disable iff (clr)
        (load_n && dn_rise && !up_rise && up_lvl) |=> count_o == $past(count_o) - 1'b1);

    // R3: clear forces zero
    always @(negedge clk) begin
        if (clr) begin
            a_r3_clear_zero: assert (count_o == '0 && !fault_o);
        end
    end

    // R4: load copies data
    a_r4_load_copy: assert property (@(posedge clk) disable iff (clr)
        !load_n |=> count_o == $past(data_in));

    // R5: carry low only at top with up input low two samples back
    a_r5_carry_window: assert property (@(posedge clk) disable iff (clr)
        !carry_n |-> (count_o == TOP && !$past(inc_in, 2)));

    // R6: borrow low only at zero with down input low two samples back
    a_r6_borrow_window: assert property (@(posedge clk) disable iff (clr)
        !borrow_n |-> (count_o == '0 && !$past(dec_in, 2)));

    // R8: illegal up edge holds and flags
    a_r8_up_fault_hold: assert property (@(posedge clk) disable iff (clr)
        (load_n && up_rise && (dn_rise || !dn_lvl)) |=> ($stable(count_o) && fault_o));

    // R8: illegal down edge holds and flags
    a_r8_dn_fault_hold: assert property (@(posedge clk) disable iff (clr)
        (load_n && dn_rise && !up_rise && !up_lvl) |=> ($stable(count_o) && fault_o));

    // R8: fault is sticky
    a_r8_fault_sticky: assert property (@(posedge clk) disable iff (clr)
        fault_o |=> fault_o);

    // R1, R2: no edge, no load, no change
    a_r1_idle_hold: assert property (@(posedge clk) disable iff (clr)
        (load_n && !up_rise && !dn_rise) |=> $stable(count_o));

endmodule

bind updn_dual_counter updn_dual_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .clr(clr), .load_n(load_n), .data_in(data_in),
    .inc_in(inc_in), .dec_in(dec_in), .count_o(count_o),
    .carry_n(carry_n), .borrow_n(borrow_n), .fault_o(fault_o),
    .up_lvl(up_lvl), .up_rise(up_rise), .dn_lvl(dn_lvl), .dn_rise(dn_rise)
);

// File: tb/tb_updn_dual_counter.sv
module tb_updn_dual_counter;
    localparam int W = 4;
    localparam int MAXV = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         clr = 1'b1;
    logic         load_n = 1'b1;
    logic [W-1:0] data_in = '0;
    logic         inc_in = 1'b1;
    logic         dec_in = 1'b1;
    logic [W-1:0] count_o;
    logic         carry_n, borrow_n, fault_o;
    logic [W-1:0] hi_count;
    logic         hi_carry, hi_borrow, hi_fault;

    int n_checks = 0;
    int n_fail = 0;
    int model = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    updn_dual_counter #(.CNT_W(W), .SYNC_STAGES(2)) dut (
        .clk(clk), .clr(clr), .load_n(load_n), .data_in(data_in),
        .inc_in(inc_in), .dec_in(dec_in), .count_o(count_o),
        .carry_n(carry_n), .borrow_n(borrow_n), .fault_o(fault_o)
    );

    updn_dual_counter #(.CNT_W(W), .SYNC_STAGES(2)) hi_stage (
        .clk(clk), .clr(clr), .load_n(1'b1), .data_in('0),
        .inc_in(carry_n), .dec_in(borrow_n), .count_o(hi_count),
        .carry_n(hi_carry), .borrow_n(hi_borrow), .fault_o(hi_fault)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic up_pulse(input int ph);
        inc_in = 1'b0;
        wait_n(ph);
        chk("R5", "carry_n in low phase", int'(carry_n), (model % (MAXV + 1)) == MAXV ? 0 : 1);
        inc_in = 1'b1;
        wait_n(ph);
        model = model + 1;
    endtask

    task automatic dn_pulse(input int ph);
        dec_in = 1'b0;
        wait_n(ph);
        chk("R6", "borrow_n in low phase", int'(borrow_n), (model % (MAXV + 1)) == 0 ? 0 : 1);
        dec_in = 1'b1;
        wait_n(ph);
        model = model - 1;
    endtask

    task automatic do_clear();
        @(negedge clk);
        #1 clr = 1'b1;
        wait_n(2);
        clr = 1'b0;
        wait_n(1);
        model = 0;
    endtask

    initial begin
        wait_n(3);
        clr = 1'b0;
        wait_n(1);
        // reset state
        chk("R3", "count after clear", int'(count_o), 0);
        chk("R3", "fault after clear", int'(fault_o), 0);
        chk("R5", "carry idle", int'(carry_n), 1);
        chk("R6", "borrow idle", int'(borrow_n), 1);

        // R9: exact latency
        inc_in = 1'b0;
        wait_n(4);
        inc_in = 1'b1;
        wait_n(2);
        chk("R9", "count after two edges", int'(count_o), 0);
        wait_n(1);
        chk("R9", "count after three edges", int'(count_o), 1);
        model = 1;
        wait_n(2);

        // R1, R5, R7: up sweep with wrap
        for (int i = 0; i < 20; i++) begin
            up_pulse(4);
            chk("R1", "count after up pulse", int'(count_o), model % (MAXV + 1));
            chk("R5", "carry after rise", int'(carry_n), 1);
        end
        model = model % (MAXV + 1);

        // R2, R6, R7: down sweep with wrap
        for (int i = 0; i < 20; i++) begin
            dn_pulse(4);
            model = (model + MAXV + 1) % (MAXV + 1);
            chk("R2", "count after down pulse", int'(count_o), model);
        end
        chk("R7", "no fault from legal sweeps", int'(fault_o), 0);

        // R4: load every value
        for (int v = 0; v <= MAXV; v++) begin
            data_in = W'(v);
            load_n = 1'b0;
            wait_n(1);
            load_n = 1'b1;
            chk("R4", "loaded value", int'(count_o), v);
        end
        // R4: load held through an up pulse
        data_in = 4'd5;
        load_n = 1'b0;
        inc_in = 1'b0;
        wait_n(4);
        inc_in = 1'b1;
        wait_n(4);
        chk("R4", "count held by load", int'(count_o), 5);
        load_n = 1'b1;
        wait_n(1);

        // R3: clear while load held
        data_in = 4'd9;
        load_n = 1'b0;
        wait_n(2);
        #2 clr = 1'b1;
        #1 chk("R3", "async clear mid-cycle", int'(count_o), 0);
        wait_n(2);
        chk("R3", "clear beats load", int'(count_o), 0);
        clr = 1'b0;
        wait_n(1);
        chk("R4", "load resumes after clear", int'(count_o), 9);
        load_n = 1'b1;
        model = 9;
        wait_n(1);

        // R8: down edge while up low
        inc_in = 1'b0;
        wait_n(4);
        dec_in = 1'b0;
        wait_n(4);
        dec_in = 1'b1;
        wait_n(4);
        chk("R8", "count held on illegal down", int'(count_o), 9);
        chk("R8", "fault raised", int'(fault_o), 1);
        inc_in = 1'b1;
        wait_n(4);
        chk("R1", "legal up after fault", int'(count_o), 10);
        chk("R8", "fault sticky", int'(fault_o), 1);
        do_clear();
        chk("R3", "clear drops fault", int'(fault_o), 0);

        // R8: both rise together
        data_in = 4'd6;
        load_n = 1'b0;
        wait_n(1);
        load_n = 1'b1;
        inc_in = 1'b0;
        dec_in = 1'b0;
        wait_n(4);
        inc_in = 1'b1;
        dec_in = 1'b1;
        wait_n(4);
        chk("R8", "count held on double rise", int'(count_o), 6);
        chk("R8", "fault on double rise", int'(fault_o), 1);
        do_clear();

        // R10: cascade up then down
        for (int i = 0; i < 40; i++) begin
            up_pulse(8);
            chk("R10", "cascade up value", int'({hi_count, count_o}), model % 256);
        end
        for (int i = 0; i < 45; i++) begin
            dn_pulse(8);
            chk("R10", "cascade down value", int'({hi_count, count_o}), (model + 256) % 256);
        end
        chk("R10", "upper stage no fault", int'(hi_fault), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule